// File: doc/BRIEF.md
# Bitstream Sync Header Detector

This block watches a byte stream, one byte per accepted cycle, and decides whether the stream opens with a valid configuration-bitstream preamble. Every byte offset is a possible start. Bytes are packed into 32-bit words with the earliest byte as the most significant byte. The earliest offset at which all thirteen preamble words agree is the match.

A match at offset zero is reported as success. A match at any later offset is reported as a rejection that still carries the offset. For each of the three sync words, the detector also accepts a copy whose four bytes are reversed, and it raises a swapped flag when it does. If no match has appeared by the time a parameterised byte limit is reached, the detector rejects.

After it reports a decision, the detector ignores further bytes until a synchronous clear or a reset starts a new search.

Top module: `hdr_sync_detect`

## Requirements
- R1: After reset, and with no bytes accepted, `hdr_found`, `hdr_reject`, `hdr_swapped` and `hdr_offset` are all 0.
- R2: The 13-word preamble, with the first byte of each word as the most significant, is:
  - word 0 to word 7: 0xFFFFFFFF;
  - word 8: 0x000000BB;
  - word 9: 0x11220044;
  - word 10 and word 11: 0xFFFFFFFF;
  - word 12: 0xAA995566.

  When this preamble occupies bytes 0..51, `hdr_found` pulses for one cycle in the cycle after byte 51 is accepted, with `hdr_offset` = 0 and `hdr_swapped` = 0.
- R3: A candidate position is checked only if its first four bytes are all 0xFF. Candidates are tried in increasing byte offset, and the first one that passes is the match.
- R4: Words 8, 9 and 12 are also accepted when their four bytes arrive in reverse order. If any of them is accepted this way, `hdr_swapped` is 1 at the decision.
- R5: A word that matches neither in natural order nor reversed fails the candidate, and scanning continues at the next byte offset. An all-ones word is never treated as reversed.
- R6: A match at byte offset p > 0 produces a one-cycle `hdr_reject` pulse in the cycle after byte p+51 is accepted, with `hdr_offset` = p and `hdr_swapped` reporting the byte order.
- R7: If byte number MAX_BYTES-1, counting from 0, is accepted without completing a match, `hdr_reject` pulses in the next cycle with `hdr_offset` = 0 and `hdr_swapped` = 0. A match that completes on that same byte takes priority.
- R8: `hdr_found` and `hdr_reject` are never high together. At most one pulse is produced per search, and bytes accepted after the decision have no effect.
- R9: `clr` restarts the search. In the cycle after `clr`, no pulse is shown and `hdr_offset` and `hdr_swapped` are 0.
- R10: A byte is taken only in a cycle with `in_valid` high, so idle cycles do not change the result or its timing in bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Synchronous restart of the search |
| in_valid | input | 1 | `in_byte` holds a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| hdr_found | output | 1 | One-cycle pulse: preamble found at offset 0 |
| hdr_reject | output | 1 | One-cycle pulse: preamble at a non-zero offset, or limit reached |
| hdr_offset | output | CNT_W | Byte offset of the match, held after the decision |
| hdr_swapped | output | 1 | Some sync word arrived byte-reversed, held after the decision |

## Verification
The bench targets the following corner cases, each paired with the fault it catches:
- **One leading 0xFF before a real preamble.** This creates a false candidate at offset 0. A detector that stopped at the first all-ones word, or that did not resume one byte later, would miss the match or report the wrong offset.
- **Preamble ending on the limit byte.** A design that tests the limit before the match would reject with offset 0 instead of offset 108.
- **Partly and fully reversed sync words.** These catch a swapped flag that ignores one word.
- **All-0xFF streams.** These catch a detector that takes the dummy word as a valid reversed sync word.
- **Second preamble, idle gaps, and a clear in the middle of a stream.** These expose extra pulses, and byte counts or state that survive.

// File: rtl/hdr_sync_pkg.sv
package hdr_sync_pkg;

    localparam int          HDR_WORDS = 13;
    localparam int          HDR_BYTES = HDR_WORDS * 4;
    localparam logic [31:0] ALL_ONES  = 32'hFFFF_FFFF;

    // Expected preamble word at a given word index
    function automatic logic [31:0] hdr_expect(input int idx);
        case (idx)
            8:       return 32'h0000_00BB;
            9:       return 32'h1122_0044;
            12:      return 32'hAA99_5566;
            default: return ALL_ONES;
        endcase
    endfunction

    function automatic logic [31:0] byte_rev(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    typedef struct packed {
        logic ok;   // word accepted in either order
        logic rev;  // accepted only as a byte-reversed word
    } word_verdict_t;

    typedef enum logic {
        ST_SCAN = 1'b0,
        ST_DONE = 1'b1
    } det_state_t;

endpackage

// File: rtl/hdr_window.sv
module hdr_window
    import hdr_sync_pkg::*;
#(
    parameter int DEPTH_BYTES = HDR_BYTES,
    localparam int WIN_W = DEPTH_BYTES * 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift,
    input  logic [7:0]       din,
    output logic [WIN_W-1:0] win_next
);
    logic [WIN_W-1:0] win_q;

    // Newest byte sits in the low bits, oldest in the top bits
    always_comb begin
        win_next = shift ? {win_q[WIN_W-9:0], din} : win_q;
    end

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_next;
    end
endmodule

// File: rtl/hdr_word_cmp.sv
module hdr_word_cmp
    import hdr_sync_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic [31:0]   word,
    output word_verdict_t verdict
);
    logic [31:0] expect_w;
    logic [31:0] rev_w;
    logic        nat_hit;
    logic        rev_hit;

    always_comb begin
        expect_w    = hdr_expect(IDX);
        rev_w       = byte_rev(word);
        nat_hit     = (word == expect_w);
        rev_hit     = (rev_w != ALL_ONES) && (rev_w == expect_w);
        verdict.ok  = nat_hit || rev_hit;
        verdict.rev = rev_hit;
    end
endmodule

// File: rtl/hdr_sync_detect.sv
module hdr_sync_detect
    import hdr_sync_pkg::*;
#(
    parameter int MAX_BYTES = 4096,
    localparam int CNT_W = $clog2(MAX_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             hdr_found,
    output logic             hdr_reject,
    output logic [CNT_W-1:0] hdr_offset,
    output logic             hdr_swapped
);
    localparam int WIN_W = HDR_BYTES * 8;

    det_state_t        state;
    logic [CNT_W-1:0]  byte_cnt;
    logic              accept;
    logic [WIN_W-1:0]  win_next;
    word_verdict_t     verdict [HDR_WORDS];
    logic [HDR_WORDS-1:0] ok_vec;
    logic [HDR_WORDS-1:0] rev_vec;
    logic              win_full;
    logic              hdr_hit;
    logic              limit_hit;
    logic [CNT_W-1:0]  start_pos;

    assign accept = in_valid && (state == ST_SCAN) && !clr;

    hdr_window #(.DEPTH_BYTES(HDR_BYTES)) u_win (
        .clk      (clk),
        .rst      (rst),
        .shift    (accept),
        .din      (in_byte),
        .win_next (win_next)
    );

    // Word 0 is the oldest four bytes of the window
    for (genvar w = 0; w < HDR_WORDS; w++) begin : g_word
        hdr_word_cmp #(.IDX(w)) u_cmp (
            .word    (win_next[WIN_W-1-32*w -: 32]),
            .verdict (verdict[w])
        );
        assign ok_vec[w]  = verdict[w].ok;
        assign rev_vec[w] = verdict[w].rev;
    end

    always_comb begin
        win_full  = (32'(byte_cnt) >= 32'(HDR_BYTES - 1));
        hdr_hit   = win_full && (&ok_vec);
        limit_hit = (32'(byte_cnt) == 32'(MAX_BYTES - 1));
        start_pos = byte_cnt - CNT_W'(HDR_BYTES - 1);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            state       <= ST_SCAN;
            byte_cnt    <= '0;
            hdr_found   <= 1'b0;
            hdr_reject  <= 1'b0;
            hdr_offset  <= '0;
            hdr_swapped <= 1'b0;
        end else begin
            hdr_found  <= 1'b0;
            hdr_reject <= 1'b0;
            if (accept) begin
                byte_cnt <= byte_cnt + 1'b1;
                if (hdr_hit) begin
                    state       <= ST_DONE;
                    hdr_offset  <= start_pos;
                    hdr_swapped <= |rev_vec;
                    if (start_pos == '0) hdr_found  <= 1'b1;
                    else                 hdr_reject <= 1'b1;
                end else if (limit_hit) begin
                    state       <= ST_DONE;
                    hdr_reject  <= 1'b1;
                    hdr_offset  <= '0;
                    hdr_swapped <= 1'b0;
                end
            end
        end
    end
endmodule

// File: rtl/hdr_sync_detect_chk.sv
module hdr_sync_detect_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clr,
    input logic             in_valid,
    input logic             hdr_found,
    input logic             hdr_reject,
    input logic [CNT_W-1:0] hdr_offset,
    input logic             hdr_swapped
);
    // R8
    excl_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        !(hdr_found && hdr_reject));

    // R8
    found_once_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_found |=> !hdr_found && !hdr_reject);

    // R8
    reject_once_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_reject |=> !hdr_reject && !hdr_found);

    // R2
    found_offset_chk: assert property (@(posedge clk) disable iff (rst)
        hdr_found |-> hdr_offset == '0);

    // R7
    limit_clean_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_reject && hdr_offset == '0) |-> !hdr_swapped);

    // R9
    clear_state_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> !hdr_found && !hdr_reject && hdr_offset == '0 && !hdr_swapped);

    // R10
    pulse_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (hdr_found || hdr_reject) |-> $past(in_valid));
endmodule

bind hdr_sync_detect hdr_sync_detect_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr         (clr),
    .in_valid    (in_valid),
    .hdr_found   (hdr_found),
    .hdr_reject  (hdr_reject),
    .hdr_offset  (hdr_offset),
    .hdr_swapped (hdr_swapped)
);

// File: tb/hdr_sync_detect_tb.sv
`timescale 1ns/1ps
module hdr_sync_detect_tb;
    localparam int MAXB   = 160;
    localparam int MAXLEN = 220;
    localparam int OW     = $clog2(MAXB + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          clr = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_byte = 8'h00;
    logic          hdr_found, hdr_reject, hdr_swapped;
    logic [OW-1:0] hdr_offset;

    hdr_sync_detect #(.MAX_BYTES(MAXB)) u_dut (
        .clk(clk), .rst(rst), .clr(clr), .in_valid(in_valid), .in_byte(in_byte),
        .hdr_found(hdr_found), .hdr_reject(hdr_reject),
        .hdr_offset(hdr_offset), .hdr_swapped(hdr_swapped)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [7:0] stim [MAXLEN];
    int seen_cnt, seen_kind, seen_idx, seen_off, cur_idx;
    bit seen_sw;

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    task automatic chk(bit cond, string req, string what, int act, int exp);
        checks++;
        if (!cond) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(int w);
        if (w == 8)  return 32'h0000_00BB;
        if (w == 9)  return 32'h1122_0044;
        if (w == 12) return 32'hAA99_5566;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit hdr_at(int p, output bit sw);
        sw = 0;
        for (int w = 0; w < 13; w++) begin
            logic [31:0] wd, rv;
            wd = {stim[p+4*w], stim[p+4*w+1], stim[p+4*w+2], stim[p+4*w+3]};
            rv = {stim[p+4*w+3], stim[p+4*w+2], stim[p+4*w+1], stim[p+4*w]};
            if (rv != 32'hFFFF_FFFF && rv == exp_word(w)) sw = 1;
            else if (wd != exp_word(w)) return 0;
        end
        return 1;
    endfunction

    // kind: 0 none, 1 found, 2 reject
    task automatic model(int len, output int kind, output int idx,
                         output int off, output bit sw);
        kind = 0; idx = -1; off = 0; sw = 0;
        for (int i = 0; i < len; i++) begin
            bit s;
            if (i >= 51 && hdr_at(i - 51, s)) begin
                kind = (i == 51) ? 1 : 2; idx = i; off = i - 51; sw = s;
                return;
            end
            if (i == MAXB - 1) begin
                kind = 2; idx = i; off = 0; sw = 0;
                return;
            end
        end
    endtask

    task automatic fill(bit ffb);
        for (int i = 0; i < MAXLEN; i++)
            stim[i] = (ffb && $urandom_range(3) == 0) ? 8'hFF : 8'($urandom_range(254));
    endtask

    task automatic put_hdr(int pos, bit [2:0] swm);
        for (int w = 0; w < 13; w++) begin
            logic [31:0] wd;
            wd = exp_word(w);
            if ((w == 8 && swm[0]) || (w == 9 && swm[1]) || (w == 12 && swm[2]))
                wd = {wd[7:0], wd[15:8], wd[23:16], wd[31:24]};
            for (int b = 0; b < 4; b++) stim[pos+4*w+b] = wd[31-8*b -: 8];
        end
    endtask

    task automatic observe();
        if (hdr_found || hdr_reject) begin
            seen_cnt++;
            if (seen_cnt == 1) begin
                seen_kind = (hdr_found && hdr_reject) ? 3 : (hdr_found ? 1 : 2);
                seen_idx  = cur_idx;
                seen_off  = int'(hdr_offset);
                seen_sw   = hdr_swapped;
            end
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr = 1; in_valid = 0;
        @(negedge clk); clr = 0;
    endtask

    task automatic run_case(string req, int len, bit gaps);
        int kind, idx, off;
        bit sw;
        pulse_clr();
        seen_cnt = 0; seen_kind = 0; cur_idx = -1;
        for (int i = 0; i < len; i++) begin
            if (gaps && $urandom_range(3) == 0) begin
                in_valid = 0; @(negedge clk); observe();
            end
            in_valid = 1; in_byte = stim[i]; cur_idx = i;
            @(negedge clk); observe();
        end
        in_valid = 0;
        repeat (3) begin @(negedge clk); observe(); end
        model(len, kind, idx, off, sw);
        chk(seen_cnt == (kind != 0 ? 1 : 0), req, "pulse count", seen_cnt, kind != 0 ? 1 : 0);
        if (kind != 0 && seen_cnt >= 1) begin
            chk(seen_kind == kind, req, "decision kind", seen_kind, kind);
            chk(seen_idx == idx, req, "decision byte", seen_idx, idx);
            chk(seen_off == off, req, "offset", seen_off, off);
            chk(seen_sw == sw, req, "swapped", int'(seen_sw), int'(sw));
        end
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(!hdr_found && !hdr_reject, "R1", "pulses after reset", int'(hdr_found | hdr_reject), 0);
        chk(hdr_offset == '0 && !hdr_swapped, "R1", "held outputs after reset",
            int'(hdr_offset) + int'(hdr_swapped), 0);

        fill(0); put_hdr(0, 3'b000); run_case("R2", 80, 0);
        fill(0); put_hdr(0, 3'b111); run_case("R4", 80, 0);
        fill(0); put_hdr(0, 3'b100); run_case("R4", 70, 0);
        fill(0); put_hdr(0, 3'b010); run_case("R4", 70, 1);
        fill(0); put_hdr(3, 3'b001); run_case("R6", 90, 0);
        // R9 cleared outputs after an offset/swapped decision
        pulse_clr();
        chk(hdr_offset == '0 && !hdr_swapped && !hdr_found && !hdr_reject, "R9",
            "outputs after clr", int'(hdr_offset), 0);
        fill(0); stim[0] = 8'hFF; put_hdr(1, 3'b000); run_case("R3", 90, 0);
        fill(0); put_hdr(0, 3'b000); stim[37] = 8'h23; run_case("R5", 170, 0);
        fill(0); put_hdr(0, 3'b000); stim[43] = 8'h7F; run_case("R5", 170, 0);
        for (int i = 0; i < MAXLEN; i++) stim[i] = 8'hFF;
        run_case("R7", 170, 0);
        fill(0); put_hdr(108, 3'b011); run_case("R7", 170, 0);
        fill(0); put_hdr(0, 3'b000); put_hdr(60, 3'b111); run_case("R8", 130, 0);
        // R9 partial header, then restart mid-stream
        fill(0); put_hdr(0, 3'b000);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk); in_valid = 1; in_byte = stim[i];
        end
        run_case("R9", 60, 0);
        fill(0); put_hdr(0, 3'b101); run_case("R10", 60, 1);

        for (int n = 0; n < 40; n++) begin
            int sel, len;
            sel = $urandom_range(3);
            len = 60 + $urandom_range(159);
            fill(1);
            if (sel == 0) put_hdr(0, 3'($urandom_range(7)));
            else if (sel == 1) put_hdr($urandom_range(len - 52), 3'($urandom_range(7)));
            else if (sel == 2) begin
                int p;
                p = $urandom_range(len - 52);
                put_hdr(p, 3'($urandom_range(7)));
                stim[p + 32 + $urandom_range(19)] = 8'h5A;
            end
            run_case("R3", len, $urandom_range(1) == 1);
        end
        summary();
    end
endmodule